// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

The block collects single-cycle event pulses from a transmit queue engine, a host bus interface and a beacon timer into five secondary status registers, and presents a primary status register whose group bits are each the OR of one family of secondary bits. Software masks individual secondary bits with per-register secondary masks and masks the group bits with a primary mask. A global enable gates the single interrupt output.

Every status bit is write-1-to-clear. Writing 1 to a group bit in the primary register clears every secondary bit of that family in one write. A handler can therefore acknowledge a whole class of events at once, or clear queue bits one at a time through the secondary register. A small set of direct events is held in the primary register itself, with no secondary register behind them. Access is through a plain register port: a write strobe, a word address, write data, and read data that shows the addressed register in the same cycle.

Top module: `irq2_ctrl`

## Requirements
- R1: After reset every status, mask and enable register reads 0, and `irq` is low.
- R2: An event pulse sets its secondary bit on the next clock. The layout is as follows, with NQ = 10. Register 0 holds transmit-ok in [NQ-1:0] and descriptor-done in [2NQ-1:NQ]. Register 1 holds transmit-error in [NQ-1:0] and end-of-list in [2NQ-1:NQ]. Register 2 holds underrun in [NQ-1:0], host errors (master abort, system error, parity, in that order) in [NQ+2:NQ], and beacon events (TIM, DTIM, DTIM sync, beacon timeout, CAB timeout) in [NQ+7:NQ+3]. Register 3 holds CBR overrun in [NQ-1:0] and CBR underrun in [2NQ-1:NQ]. Register 4 holds the trigger bits in [NQ-1:0].
- R3: Writing a secondary status register (word address 8+k) clears exactly the bits written as 1 and leaves the others unchanged.
- R4: An event in the same cycle as a clear of its bit, whether that clear is direct or by group, leaves the bit set.
- R5: Primary status (address 0) bits 0..9 are, in order: transmit-ok, descriptor-done, transmit-error, end-of-list, underrun, host-error, beacon-misc, CBR overrun, CBR underrun, trigger. Each is the OR of its secondary family ANDed with that register's secondary mask (address 16+k).
- R6: Writing 1 to primary bit j (j < 10) clears every secondary bit of family j and no other secondary bit.
- R7: Primary bits 10..13 hold four direct events, which are set by pulse and cleared by writing 1.
- R8: `irq` is high exactly when the global enable (address 2, bit 0) is 1 and primary status AND primary mask (address 1) is non-zero.
- R9: With the global enable at 0, `irq` stays low whatever status and masks hold.
- R10: The pending register (address 3) reads `irq` in bit 0 and 0 elsewhere.
- R11: Mask and enable registers read back what was written, limited to their implemented bits. Writes to the pending register and to unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| ev_txok | input | NQ | Per-queue transmit-ok pulses |
| ev_desc | input | NQ | Per-queue descriptor-done pulses |
| ev_txerr | input | NQ | Per-queue transmit-error pulses |
| ev_eol | input | NQ | Per-queue end-of-list pulses |
| ev_urn | input | NQ | Per-queue underrun pulses |
| ev_hif | input | 3 | Host errors: master abort, system error, parity |
| ev_bcn | input | 5 | Beacon events: TIM, DTIM, DTIM sync, beacon timeout, CAB timeout |
| ev_cbr_over | input | NQ | Per-queue CBR overrun pulses |
| ev_cbr_under | input | NQ | Per-queue CBR underrun pulses |
| ev_trig | input | NQ | Per-queue trigger pulses |
| ev_direct | input | NDIR | Direct primary events |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach is a group clear written to the primary register in the same cycle that a new event arrives on another queue of the same family. The surviving bit must stay set while its neighbours are cleared. The stimulus first fills several queues of one family, then issues the group clear with exactly one fresh pulse on a different queue in that write cycle, and reads the secondary register back. A second case sets secondary bits while their secondary mask is zero, which lets the bench confirm that the primary group bit stays low until the mask opens.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int NSEC  = 5;
  localparam int NSUM  = 10;
  localparam int NHIF  = 3;
  localparam int NBCN  = 5;

  localparam logic [AW-1:0] A_PSTAT      = 5'd0;
  localparam logic [AW-1:0] A_PMASK      = 5'd1;
  localparam logic [AW-1:0] A_GEN        = 5'd2;
  localparam logic [AW-1:0] A_PEND       = 5'd3;
  localparam int            A_SSTAT_BASE = 8;
  localparam int            A_SMASK_BASE = 16;

  typedef enum int {
    G_TXOK = 0, G_TXDESC = 1, G_TXERR = 2, G_TXEOL = 3, G_TXURN = 4,
    G_HIF = 5, G_BCN = 6, G_CBRO = 7, G_CBRU = 8, G_TRIG = 9
  } group_e;

  typedef logic [NSEC-1:0][DW-1:0] sec_arr_t;

  function automatic logic [DW-1:0] lowmask(input int n);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < DW; i++) if (i < n) r[i] = 1'b1;
    return r;
  endfunction

  function automatic int sec_width(input int k, input int nq);
    case (k)
      2:       return nq + NHIF + NBCN;
      4:       return nq;
      default: return 2 * nq;
    endcase
  endfunction

  function automatic int group_reg(input int g);
    case (g)
      G_TXOK, G_TXDESC:       return 0;
      G_TXERR, G_TXEOL:       return 1;
      G_TXURN, G_HIF, G_BCN:  return 2;
      G_CBRO, G_CBRU:         return 3;
      default:                return 4;
    endcase
  endfunction

  function automatic logic [DW-1:0] group_bits(input int g, input int nq);
    case (g)
      G_TXDESC, G_TXEOL, G_CBRU: return lowmask(nq) << nq;
      G_HIF:                     return lowmask(NHIF) << nq;
      G_BCN:                     return lowmask(NBCN) << (nq + NHIF);
      default:                   return lowmask(nq);
    endcase
  endfunction
endpackage

// File: rtl/irq2_w1c_bank.sv
module irq2_w1c_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | evt;
  end

  assign stat = stat_q;
endmodule

// File: rtl/irq2_summary.sv
module irq2_summary
  import irq2_pkg::*;
#(
  parameter int NQ = 10
) (
  input  sec_arr_t          sec,
  input  sec_arr_t          smask,
  output logic [NSUM-1:0]   sum
);
  for (genvar g = 0; g < NSUM; g++) begin : g_sum
    localparam int            RG = group_reg(g);
    localparam logic [DW-1:0] GB = group_bits(g, NQ);
    assign sum[g] = |(sec[RG] & smask[RG] & GB);
  end
endmodule

// File: rtl/irq2_regfile.sv
module irq2_regfile
  import irq2_pkg::*;
#(
  parameter int NQ   = 10,
  parameter int NDIR = 4,
  localparam int NP  = NSUM + NDIR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NP-1:0]  pstat,
  input  sec_arr_t       sec,
  input  logic           irq,
  output logic [NP-1:0]  pmask,
  output sec_arr_t       smask,
  output logic           gen,
  output logic [DW-1:0]  rdata
);
  logic [NP-1:0] pmask_q;
  sec_arr_t      smask_q;
  logic          gen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask_q <= '0;
      smask_q <= '0;
      gen_q   <= 1'b0;
    end else if (wr) begin
      if (addr == A_PMASK) pmask_q <= wdata[NP-1:0];
      if (addr == A_GEN)   gen_q   <= wdata[0];
      for (int k = 0; k < NSEC; k++)
        if (addr == AW'(A_SMASK_BASE + k))
          smask_q[k] <= wdata & lowmask(sec_width(k, NQ));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PSTAT: rdata = DW'(pstat);
      A_PMASK: rdata = DW'(pmask_q);
      A_GEN:   rdata = DW'(gen_q);
      A_PEND:  rdata = DW'(irq);
      default: begin
        for (int k = 0; k < NSEC; k++) begin
          if (addr == AW'(A_SSTAT_BASE + k)) rdata = sec[k];
          if (addr == AW'(A_SMASK_BASE + k)) rdata = smask_q[k];
        end
      end
    endcase
  end

  assign pmask = pmask_q;
  assign smask = smask_q;
  assign gen   = gen_q;
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
  import irq2_pkg::*;
#(
  parameter int NQ   = 10,
  parameter int NDIR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NQ-1:0]    ev_txok,
  input  logic [NQ-1:0]    ev_desc,
  input  logic [NQ-1:0]    ev_txerr,
  input  logic [NQ-1:0]    ev_eol,
  input  logic [NQ-1:0]    ev_urn,
  input  logic [2:0]       ev_hif,
  input  logic [4:0]       ev_bcn,
  input  logic [NQ-1:0]    ev_cbr_over,
  input  logic [NQ-1:0]    ev_cbr_under,
  input  logic [NQ-1:0]    ev_trig,
  input  logic [NDIR-1:0]  ev_direct,
  output logic             irq
);
  localparam int NP = NSUM + NDIR;

  sec_arr_t          sevt;
  sec_arr_t          sclr;
  sec_arr_t          sec_w;
  sec_arr_t          smask_w;
  logic [NSUM-1:0]   sum_w;
  logic [NDIR-1:0]   dir_q;
  logic [NDIR-1:0]   dir_clr;
  logic [NP-1:0]     pstat_w;
  logic [NP-1:0]     pmask_w;
  logic              gen_w;
  logic              pstat_wr;

  // event routing into the secondary layout
  always_comb begin
    sevt = '0;
    sevt[0][NQ-1:0]           = ev_txok;
    sevt[0][2*NQ-1:NQ]        = ev_desc;
    sevt[1][NQ-1:0]           = ev_txerr;
    sevt[1][2*NQ-1:NQ]        = ev_eol;
    sevt[2][NQ-1:0]           = ev_urn;
    sevt[2][NQ +: NHIF]       = ev_hif;
    sevt[2][NQ+NHIF +: NBCN]  = ev_bcn;
    sevt[3][NQ-1:0]           = ev_cbr_over;
    sevt[3][2*NQ-1:NQ]        = ev_cbr_under;
    sevt[4][NQ-1:0]           = ev_trig;
  end

  assign pstat_wr = bus_wr && (bus_addr == A_PSTAT);

  // direct and group clears
  always_comb begin
    for (int k = 0; k < NSEC; k++) begin
      sclr[k] = '0;
      if (bus_wr && bus_addr == AW'(A_SSTAT_BASE + k)) sclr[k] = bus_wdata;
    end
    if (pstat_wr)
      for (int g = 0; g < NSUM; g++)
        if (bus_wdata[g]) sclr[group_reg(g)] = sclr[group_reg(g)] | group_bits(g, NQ);
    for (int k = 0; k < NSEC; k++)
      sclr[k] = sclr[k] & lowmask(sec_width(k, NQ));
  end

  assign dir_clr = pstat_wr ? bus_wdata[NP-1:NSUM] : '0;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    irq2_w1c_bank #(.W(DW)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (sevt[k]),
      .clr  (sclr[k]),
      .stat (sec_w[k])
    );
  end

  irq2_w1c_bank #(.W(NDIR)) u_direct (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (ev_direct),
    .clr  (dir_clr),
    .stat (dir_q)
  );

  irq2_summary #(.NQ(NQ)) u_sum (
    .sec  (sec_w),
    .smask(smask_w),
    .sum  (sum_w)
  );

  assign pstat_w = {dir_q, sum_w};
  assign irq     = gen_w & (|(pstat_w & pmask_w));

  irq2_regfile #(.NQ(NQ), .NDIR(NDIR)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (bus_wr),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .pstat(pstat_w),
    .sec  (sec_w),
    .irq  (irq),
    .pmask(pmask_w),
    .smask(smask_w),
    .gen  (gen_w),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/irq2_ctrl_chk.sv
module irq2_ctrl_chk
  import irq2_pkg::*;
#(
  parameter int NQ = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [4:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [NQ-1:0] ev_txok,
  input logic [4:0]    ev_bcn,
  input logic          irq,
  input logic          gen_w,
  input logic [31:0]   sec0,
  input logic [31:0]   sec2
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bcn[0] |=> sec2[NQ+NHIF]); // R2

  AST_W1C_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'd8 && bus_wdata[0] && !ev_txok[0]) |=> !sec0[0]); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'd8 && bus_wdata[0] && ev_txok[0]) |=> sec0[0]); // R4

  AST_GROUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PSTAT && bus_wdata[0] && ev_txok == '0) |=> (sec0[NQ-1:0] == '0)); // R6

  AST_GEN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_w |-> !irq); // R9

  AST_PEND_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PEND) |-> (bus_rdata == {31'b0, irq})); // R10
endmodule

bind irq2_ctrl irq2_ctrl_chk #(.NQ(NQ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .ev_txok  (ev_txok),
  .ev_bcn   (ev_bcn),
  .irq      (irq),
  .gen_w    (gen_w),
  .sec0     (sec_w[0]),
  .sec2     (sec_w[2])
);

// File: tb/irq2_ctrl_test.sv
`timescale 1ns/1ps
module irq2_ctrl_test;
  localparam int NQ = 10;
  localparam int ND = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NQ-1:0] e_txok = 0, e_desc = 0, e_txerr = 0, e_eol = 0, e_urn = 0;
  logic [NQ-1:0] e_cbro = 0, e_cbru = 0, e_trig = 0;
  logic [2:0] e_hif = 0;
  logic [4:0] e_bcn = 0;
  logic [ND-1:0] e_dir = 0;
  logic irq;

  always #10 clk = ~clk;

  irq2_ctrl #(.NQ(NQ), .NDIR(ND)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_txok(e_txok), .ev_desc(e_desc), .ev_txerr(e_txerr), .ev_eol(e_eol),
    .ev_urn(e_urn), .ev_hif(e_hif), .ev_bcn(e_bcn), .ev_cbr_over(e_cbro),
    .ev_cbr_under(e_cbru), .ev_trig(e_trig), .ev_direct(e_dir), .irq(irq)
  );

  // reference model state
  logic [31:0] m_sec [5];
  logic [31:0] m_smask [5];
  logic [13:0] m_pmask;
  logic [ND-1:0] m_dir;
  logic m_gen;
  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  function automatic int fam_reg(int s);
    int t[10] = '{0, 0, 1, 1, 2, 2, 2, 3, 3, 4};
    return t[s];
  endfunction
  function automatic int fam_lo(int s);
    if (s == 1 || s == 3 || s == 8) return NQ;
    if (s == 5) return NQ;
    if (s == 6) return NQ + 3;
    return 0;
  endfunction
  function automatic int fam_n(int s);
    if (s == 5) return 3;
    if (s == 6) return 5;
    return NQ;
  endfunction
  function automatic int reg_w(int k);
    if (k == 2) return NQ + 8;
    if (k == 4) return NQ;
    return 2 * NQ;
  endfunction

  function automatic logic [9:0] m_summary();
    logic [9:0] r = '0;
    for (int s = 0; s < 10; s++)
      for (int b = fam_lo(s); b < fam_lo(s) + fam_n(s); b++)
        if (m_sec[fam_reg(s)][b] && m_smask[fam_reg(s)][b]) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [13:0] m_pstat();
    return {m_dir, m_summary()};
  endfunction

  function automatic logic m_irq();
    return m_gen && ((m_pstat() & m_pmask) != 0);
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    int ai = int'(a);
    if (ai == 0) return 32'(m_pstat());
    if (ai == 1) return 32'(m_pmask);
    if (ai == 2) return 32'(m_gen);
    if (ai == 3) return 32'(m_irq());
    if (ai >= 8 && ai < 13) return m_sec[ai-8];
    if (ai >= 16 && ai < 21) return m_smask[ai-16];
    return 32'h0;
  endfunction

  function automatic logic [31:0] wmask(int w);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic m_update();
    logic [31:0] ev [5];
    logic [31:0] cl [5];
    ev[0] = 32'(e_txok) | (32'(e_desc) << NQ);
    ev[1] = 32'(e_txerr) | (32'(e_eol) << NQ);
    ev[2] = 32'(e_urn) | (32'(e_hif) << NQ) | (32'(e_bcn) << (NQ + 3));
    ev[3] = 32'(e_cbro) | (32'(e_cbru) << NQ);
    ev[4] = 32'(e_trig);
    for (int k = 0; k < 5; k++) cl[k] = (bus_wr && int'(bus_addr) == 8 + k) ? bus_wdata : 32'h0;
    if (bus_wr && bus_addr == 0)
      for (int s = 0; s < 10; s++)
        if (bus_wdata[s])
          for (int b = fam_lo(s); b < fam_lo(s) + fam_n(s); b++) cl[fam_reg(s)][b] = 1'b1;
    for (int k = 0; k < 5; k++) m_sec[k] = ((m_sec[k] & ~cl[k]) | ev[k]) & wmask(reg_w(k));
    m_dir = (m_dir & ~((bus_wr && bus_addr == 0) ? bus_wdata[13:10] : 4'h0)) | e_dir;
    if (bus_wr) begin
      if (bus_addr == 1) m_pmask = bus_wdata[13:0];
      if (bus_addr == 2) m_gen = bus_wdata[0];
      for (int k = 0; k < 5; k++)
        if (int'(bus_addr) == 16 + k) m_smask[k] = bus_wdata & wmask(reg_w(k));
    end
  endtask

  task automatic clear_events();
    e_txok = 0; e_desc = 0; e_txerr = 0; e_eol = 0; e_urn = 0;
    e_cbro = 0; e_cbru = 0; e_trig = 0; e_hif = 0; e_bcn = 0; e_dir = 0;
  endtask

  task automatic step(bit we, logic [4:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    bus_wr = we; bus_addr = a; bus_wdata = d;
    #2;
    vectors++;
    if (bus_rdata !== m_read(a)) begin
      errors++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, a, bus_rdata, m_read(a));
    end
    vectors++;
    if (irq !== m_irq()) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq());
    end
    @(posedge clk);
    m_update();
    #1;
    clear_events();
    bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    step(0, a, 32'h0, tag);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int k = 0; k < 5; k++) begin m_sec[k] = 0; m_smask[k] = 0; end
    m_pmask = 0; m_dir = 0; m_gen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state of every implemented address
    foreach (m_sec[k]) begin rd(5'(8 + k), "R1"); rd(5'(16 + k), "R1"); end
    rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(3, "R1");

    // R11: masks read back, limited to implemented bits
    for (int k = 0; k < 5; k++) begin step(1, 5'(16 + k), 32'hFFFF_FFFF, "R11"); rd(5'(16 + k), "R11"); end
    step(1, 1, 32'hFFFF_FFFF, "R11"); rd(1, "R11");

    // R2, R5, R9: event sets bit and group, enable still off
    e_txok[3] = 1; rd(8, "R2");
    rd(8, "R2"); rd(0, "R5"); rd(3, "R9");
    // R8, R10: enable on
    step(1, 2, 32'h1, "R8"); rd(3, "R10"); rd(0, "R8");
    // R3: single-bit clear
    e_txok[5] = 1; rd(8, "R2");
    step(1, 8, 32'h8, "R3"); rd(8, "R3"); rd(0, "R5");
    // R4: clear of bit 5 racing a new pulse on bit 5
    e_txok[5] = 1; step(1, 8, 32'h20, "R4"); rd(8, "R4");
    // R2: other families
    e_hif = 3'b101; e_bcn = 5'b10010; e_urn[9] = 1; rd(10, "R2");
    rd(10, "R2"); rd(0, "R5");
    e_eol[0] = 1; e_cbru[4] = 1; e_trig[8] = 1; e_desc[2] = 1; rd(9, "R2");
    rd(9, "R2"); rd(11, "R2"); rd(12, "R2"); rd(8, "R2"); rd(0, "R5");
    // R6 + R4: group clear of transmit-ok while queue 7 pulses
    e_txok[2] = 1; e_txok[6] = 1; rd(8, "R6");
    e_txok[7] = 1; step(1, 0, 32'h1, "R6"); rd(8, "R6"); rd(0, "R6");
    // R6: host-error group clear leaves beacon bits
    step(1, 0, 32'h20, "R6"); rd(10, "R6"); rd(0, "R6");
    // R5: closed secondary mask hides family
    step(1, 18, 32'h0, "R5"); rd(0, "R5"); rd(10, "R5");
    step(1, 18, 32'hFFFF_FFFF, "R5"); rd(0, "R5");
    // R7: direct bits
    e_dir = 4'b1010; rd(0, "R7");
    rd(0, "R7"); step(1, 0, 32'h0000_0800, "R7"); rd(0, "R7");
    // R8: primary mask limits output
    step(1, 0, 32'h3FFF, "R8"); rd(0, "R8"); rd(3, "R8");
    e_trig[1] = 1; step(1, 1, 32'h0000_0001, "R8"); rd(3, "R8");
    step(1, 1, 32'h0000_0200, "R8"); rd(3, "R8");
    // R9: enable off with a pending masked status
    step(1, 2, 32'h0, "R9"); rd(3, "R9"); rd(0, "R9");
    // R11: pending and unused writes ignored
    step(1, 3, 32'hFFFF_FFFF, "R11"); rd(3, "R11");
    step(1, 5'd25, 32'hFFFF_FFFF, "R11"); rd(2, "R11"); rd(1, "R11");
    step(1, 2, 32'h1, "R8");

    // mixed traffic against the model
    lf = 32'hACE1_2357;
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      int sel;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      e_txok = NQ'(lf & (lf >> 7) & (lf >> 13));
      e_eol  = NQ'((lf >> 3) & (lf >> 11) & (lf >> 19));
      e_bcn  = 5'((lf >> 5) & (lf >> 17) & (lf >> 23));
      e_trig = NQ'((lf >> 2) & (lf >> 9) & (lf >> 21));
      e_dir  = ND'((lf >> 4) & (lf >> 12) & (lf >> 27));
      sel = int'(lf[27:24]);
      case (sel % 8)
        0, 1, 2: a = 5'(lf[31:29]);
        3:       a = 5'(8 + (int'(lf[30:28]) % 5));
        4:       a = 5'(16 + (int'(lf[30:28]) % 5));
        default: a = 5'(8 + (int'(lf[29:28]) % 4));
      endcase
      if (lf[15] && lf[16] && a != 2) step(1, a, {lf[7:0], lf[31:8]}, "R5");
      else rd(a, "R5");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule